// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block produces the system reset for a processor from two independent sources. The first is a supply monitor: a clean digital supply-good flag, driven by an external comparator, holds the reset active while it is low. The reset is released only once the flag has stayed high without a break for a fixed hold time. The second source is a watchdog timer. A falling edge on the chip-select line doubles as a watchdog kick. If no falling edge arrives within the selected period, the block forces the same reset and holds it for the same hold time.

A 2-bit period code, normally taken from a nonvolatile status field, selects one of three timeout periods or turns the watchdog off. All delays count milliseconds from a prescaled tick. A parameter sets the number of clock cycles per tick, so a bench can shorten every delay. A parameter also sets the polarity of the reset output. A separate busy flag follows the reset state, and the serial command decoder uses it to refuse every read and write instruction while reset is active. The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control and status signals.

Top module: `supv_reset_wdog`

## Requirements
- R1: After the power-on reset input `rst_n` is released, the reset output is active and `busy` is 1 until a release sequence completes.
- R2: When `supply_ok` is low at a clock edge, the reset is active from that edge onward.
- R3: The reset is released only after `supply_ok` has stayed high for HOLD_MS consecutive ticks. The release falls between (HOLD_MS-1)*TICKS_PER_MS+1 and HOLD_MS*TICKS_PER_MS clock edges after `supply_ok` is first seen high.
- R4: If `supply_ok` drops during the release countdown, the countdown starts again from zero once the supply returns.
- R5: Period code 2'b11 (the power-on default of the latched code) disables the watchdog. With this code, no reset occurs however long the kick line stays idle.
- R6: Period codes 2'b00, 2'b01 and 2'b10 select the slow (nominally 1400 ms), medium (600 ms) and fast (200 ms) timeouts. If no falling edge arrives, the reset goes active between (P-1)*TICKS_PER_MS+1 and P*TICKS_PER_MS edges after the last restart. This applies whether the kick line sits high or low.
- R7: A high-to-low transition on `wdi_cs` restarts the watchdog count, and a rising edge does not. Falling edges spaced closer than the period keep the reset released.
- R8: After a watchdog timeout, the reset stays active for HOLD_MS ticks and is then released. The watchdog count is held at zero while the reset is active.
- R9: A change of `wd_sel` takes effect only at the next watchdog restart, which is a falling edge or a reset release.
- R10: With ACTIVE_LOW=1, `reset_out` is low when reset is active. With ACTIVE_LOW=0, it is high. The timing is the same in both cases.
- R11: `busy` is 1 exactly when the reset is active, whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supply above trip point (digital comparator result) |
| wdi_cs | input | 1 | Chip-select line; its falling edge kicks the watchdog |
| wd_sel | input | 2 | Watchdog period code from the status field |
| reset_out | output | 1 | System reset, polarity set by ACTIVE_LOW |
| busy | output | 1 | High while reset is active; blocks command decoding |

## Verification
A low supply flag shows on the outputs one clock edge later, so the bench drives it at a falling clock edge and samples at the next falling edge. Every timed result depends on the phase of the free-running tick, which leaves one tick of uncertainty. Each delay is therefore checked as a pair of samples. The first is taken (N-1)*TICKS_PER_MS-1 cycles after the stimulus, where the old state must still hold. The second is taken N*TICKS_PER_MS+2 cycles after it, where the new state must be present. N is HOLD_MS for release checks and the selected period for watchdog checks. For a release that follows a watchdog timeout, the bench first polls for the reset edge and then measures from that point.

// File: rtl/srw_pkg.sv
package srw_pkg;
  typedef enum logic [1:0] {
    WD_SLOW = 2'b00,
    WD_MID  = 2'b01,
    WD_FAST = 2'b10,
    WD_OFF  = 2'b11
  } wd_code_e;
endpackage

// File: rtl/srw_tick.sv
module srw_tick #(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS_PER_MS - 1);

  logic [TW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + TW'(1);
  end
endmodule

// File: rtl/srw_hold.sv
module srw_hold #(
  parameter int HOLD_MS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_fire,
  output logic in_reset
);
  localparam int CW = $clog2(HOLD_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

  logic [CW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset <= 1'b1;
      hold_q   <= '0;
    end else if (!supply_ok || wd_fire) begin
      in_reset <= 1'b1;
      hold_q   <= '0;
    end else if (in_reset && tick) begin
      if (hold_q == LAST) begin
        in_reset <= 1'b0;
        hold_q   <= '0;
      end else begin
        hold_q <= hold_q + CW'(1);
      end
    end
  end

  AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> in_reset); // R2

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset) |-> $past(supply_ok)); // R3

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q < CW'(HOLD_MS)); // R4
endmodule

// File: rtl/srw_wdog.sv
module srw_wdog
  import srw_pkg::*;
#(
  parameter int SLOW_MS = 1400,
  parameter int MID_MS  = 600,
  parameter int FAST_MS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_reset,
  input  logic       wdi,
  input  logic [1:0] wd_sel,
  output logic       fire
);
  localparam int MAXP = (SLOW_MS > MID_MS) ? ((SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS)
                                           : ((MID_MS > FAST_MS) ? MID_MS : FAST_MS);
  localparam int WW = $clog2(MAXP + 1);

  wd_code_e      per_q;
  logic [WW-1:0] cnt_q;
  logic [WW-1:0] limit;
  logic          wdi_q;
  logic          kick;
  logic          enabled;

  always_comb begin
    unique case (per_q)
      WD_SLOW: limit = WW'(SLOW_MS);
      WD_MID:  limit = WW'(MID_MS);
      WD_FAST: limit = WW'(FAST_MS);
      default: limit = '0;
    endcase
  end

  assign enabled = (per_q != WD_OFF);
  assign kick    = wdi_q && !wdi;
  assign fire    = enabled && !in_reset && !kick && tick && (cnt_q == limit - WW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdi_q <= 1'b1;
      cnt_q <= '0;
      per_q <= WD_OFF;
    end else begin
      wdi_q <= wdi;
      if (in_reset || kick) begin
        cnt_q <= '0;
        per_q <= wd_code_e'(wd_sel);
      end else if (enabled && tick) begin
        cnt_q <= cnt_q + WW'(1);
      end
    end
  end

  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> (cnt_q == '0)); // R8

  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == WD_OFF) |-> !fire); // R5

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !in_reset) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog #(
  parameter int TICKS_PER_MS = 1000,
  parameter int HOLD_MS      = 200,
  parameter int SLOW_MS      = 1400,
  parameter int MID_MS       = 600,
  parameter int FAST_MS      = 200,
  parameter bit ACTIVE_LOW   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       wdi_cs,
  input  logic [1:0] wd_sel,
  output logic       reset_out,
  output logic       busy
);
  logic tick;
  logic in_reset;
  logic wd_fire;

  srw_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  srw_hold #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .wd_fire(wd_fire), .in_reset(in_reset)
  );

  srw_wdog #(.SLOW_MS(SLOW_MS), .MID_MS(MID_MS), .FAST_MS(FAST_MS)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_reset(in_reset),
    .wdi(wdi_cs), .wd_sel(wd_sel), .fire(wd_fire)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign reset_out = ~in_reset;
    end else begin : g_high
      assign reset_out = in_reset;
    end
  endgenerate

  assign busy = in_reset;

  AST_FIRE_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> busy); // R8
endmodule

// File: tb/tb_supv_reset_wdog.sv
module tb_supv_reset_wdog;
  localparam int T    = 4;
  localparam int HOLD = 10;
  localparam int PS   = 30;
  localparam int PM   = 20;
  localparam int PF   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic wdi_cs = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic rout_lo, busy_lo, rout_hi, busy_hi;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  supv_reset_wdog #(.TICKS_PER_MS(T), .HOLD_MS(HOLD), .SLOW_MS(PS), .MID_MS(PM),
    .FAST_MS(PF), .ACTIVE_LOW(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdi_cs(wdi_cs),
    .wd_sel(wd_sel), .reset_out(rout_lo), .busy(busy_lo));

  supv_reset_wdog #(.TICKS_PER_MS(T), .HOLD_MS(HOLD), .SLOW_MS(PS), .MID_MS(PM),
    .FAST_MS(PF), .ACTIVE_LOW(1'b0)) dut_hi (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdi_cs(wdi_cs),
    .wd_sel(wd_sel), .reset_out(rout_hi), .busy(busy_hi));

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Compares reset state of both polarity variants; R10 and R11 on every call.
  task automatic expect_rst(input bit act, input string tag);
    logic [3:0] got, exp;
    got = {rout_lo, busy_lo, rout_hi, busy_hi};
    exp = {~act, act, act, act};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (R10 R11) {lo,busy,hi,busy_hi} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic kick();
    wdi_cs = 1'b1; cyc(2);
    wdi_cs = 1'b0;
  endtask

  task automatic wait_release(input string tag);
    int k = 0;
    while (busy_lo && k < 1000) begin cyc(1); k++; end
    n_chk++;
    if (busy_lo) begin n_bad++; $display("FAIL %s release actual=1 expected=0", tag); end
  endtask

  task automatic t_power_on();
    expect_rst(1'b1, "R1 reset state");
    supply_ok = 1'b1;
    cyc(30);
    supply_ok = 1'b0; cyc(3);
    supply_ok = 1'b1;
    cyc((HOLD-1)*T - 1);
    expect_rst(1'b1, "R4 countdown restarted");
    cyc(T + 3);
    expect_rst(1'b0, "R3 released after hold");
  endtask

  task automatic t_disabled();
    cyc(200);
    expect_rst(1'b0, "R5 code 11 never fires");
  endtask

  task automatic t_period(input logic [1:0] code, input int p, input string tag);
    wd_sel = code;
    kick();
    cyc((p-1)*T - 1);
    expect_rst(1'b0, {tag, " before timeout"});
    cyc(T + 3);
    expect_rst(1'b1, {tag, " after timeout"});
  endtask

  task automatic t_hold_after_fire();
    cyc((HOLD-1)*T - 6);
    expect_rst(1'b1, "R8 held after timeout");
    wait_release("R8");
  endtask

  task automatic t_late_select();
    wd_sel = 2'b10;
    cyc(100);
    expect_rst(1'b0, "R9 new code waits for restart");
    t_period(2'b10, PF, "R9 R6 fast code");
  endtask

  task automatic t_kicks();
    wd_sel = 2'b10;
    kick();
    for (int i = 0; i < 6; i++) begin
      cyc(10); wdi_cs = 1'b1; cyc(20); wdi_cs = 1'b0;
    end
    cyc(2);
    expect_rst(1'b0, "R7 periodic kicks hold off");
    cyc(20); wdi_cs = 1'b1;
    cyc(PF*T - 20 + 2);
    expect_rst(1'b1, "R7 rising edge does not restart");
    wait_release("R7");
  endtask

  task automatic t_supply_drop();
    supply_ok = 1'b0; cyc(1);
    expect_rst(1'b1, "R2 supply low");
    supply_ok = 1'b1;
    wait_release("R2");
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    t_power_on();
    t_disabled();
    t_late_select();
    t_hold_after_fire();
    t_period(2'b00, PS, "R6 slow code");
    wait_release("R6 slow");
    t_period(2'b01, PM, "R6 medium code");
    wait_release("R6 medium");
    t_kicks();
    t_supply_drop();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule